// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter

This block sends host data words one bit at a time on a serial data line, paced by a shift clock from a remote master. It never makes a clock of its own. The external clock is brought into the system clock domain through a synchroniser, and the block detects its falling edges there. Each falling edge moves the data line to the next bit, so the master can sample a steady value on its rising edge.

Words are double-buffered. The host writes a word into a holding register. When the transmit shift register is idle, the word moves into it and is sent least-significant bit first. A second word can wait in the holding register while the first is still shifting. The empty flag and the interrupt request follow only the holding register. A separate status shows when the shifter is idle.

A ninth data bit can be sent after the eight data bits. A write made while the holding register is full is dropped and recorded in a sticky overflow status, which the host clears.

Top module: `sss_slave_tx`

## Requirements
- R1: After reset, `shift_empty` = 1, `hold_empty` = 1, `wr_ovf` = 0 and `sdo` = 1.
- R2: Transmission is active only while `port_on`, `sync_sel` and `tx_on` are 1 and `clk_master_sel`, `rx_cont_on` and `rx_single_on` are 0. While it is inactive, a written word stays in the holding register (`hold_empty` = 0, `shift_empty` = 1), `sdo` stays at 1, and external clock edges shift nothing.
- R3: A word written with both registers empty reaches the shifter within two system clocks of the write strobe. `shift_empty` then reads 0, `hold_empty` reads 1, and `sdo` shows bit 0.
- R4: Bits leave least-significant first. `sdo` changes only a few system clocks after a falling edge of `ext_sck` (or when a word is loaded), and it is steady at every rising edge.
- R5: A second word written while the first is shifting stays in the holding register, and `hold_empty` remains 0. After the last falling edge of the first word, the waiting word moves to the shifter and `hold_empty` returns to 1.
- R6: `irq` equals `hold_empty` AND `irq_on`.
- R7: If `word9_sel` = 1 at the write, the word is 9 bits long and `host_bit9` (captured with the data) is sent after data bit 7. Otherwise the word is 8 bits long.
- R8: A write while the holding register is full is ignored and sets `wr_ovf`. A pulse on `ovf_clr` clears `wr_ovf`, but a new overflow in the same cycle wins over the clear.
- R9: After the falling edge that ends the last bit, with no word waiting, `shift_empty` returns to 1 and `sdo` goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sck | input | 1 | Shift clock from the remote master, asynchronous |
| host_wr | input | 1 | Host write strobe for the holding register |
| host_data | input | 8 | Data word to be written |
| host_bit9 | input | 1 | Ninth bit, captured with the data |
| word9_sel | input | 1 | 1 selects 9-bit words, captured at the write |
| port_on | input | 1 | Serial port enable |
| sync_sel | input | 1 | Synchronous mode select |
| clk_master_sel | input | 1 | 1 = internal clock source (master), so this block stays idle |
| rx_cont_on | input | 1 | Continuous-receive enable, must be 0 for transmit |
| rx_single_on | input | 1 | Single-receive enable, must be 0 for transmit |
| tx_on | input | 1 | Transmit enable |
| irq_on | input | 1 | Interrupt enable |
| ovf_clr | input | 1 | Clears the sticky overflow status |
| sdo | output | 1 | Serial data out, idles at 1 |
| hold_empty | output | 1 | Holding register empty |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register idle |
| wr_ovf | output | 1 | Sticky write-overflow status |

## Verification
Random bytes are sent as single words and as back-to-back pairs, in both 8-bit and 9-bit mode. The single words check bit order and word length. The pairs show whether the holding register really waits, and whether its empty flag stays low until the first word is done. Directed cases hold off each of the enabling controls in turn while external clock pulses are applied, which shows whether an inactive port shifts or loads anything. A third write into a full buffer must leave the sent data unchanged and set the sticky status, and a clear afterwards must reset that status.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic              len9;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/sss_edge_sync.sv
module sss_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_async,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = sck_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], sck_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/sss_hold_reg.sv
module sss_hold_reg
  import sss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  tx_word_t word_i,
  input  logic     take_i,
  input  logic     ovf_clr_i,
  output logic     full_o,
  output tx_word_t word_o,
  output logic     ovf_o
);
  logic     full_d, ovf_d, cap_en;
  tx_word_t word_q;

  always_comb begin
    cap_en = wr_i & ~full_o;
    full_d = full_o;
    if (take_i) full_d = 1'b0;
    if (cap_en) full_d = 1'b1;
    ovf_d = ovf_o;
    if (ovf_clr_i) ovf_d = 1'b0;
    if (wr_i && full_o) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      ovf_o  <= 1'b0;
      word_q <= '0;
    end else begin
      full_o <= full_d;
      ovf_o  <= ovf_d;
      if (cap_en) word_q <= word_i;
    end
  end

  assign word_o = word_q;

  // R8
  wr_full_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_o) |=> ovf_o);
  // R8
  wr_full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_o) |=> $stable(word_o));
endmodule

// File: rtl/sss_shifter.sv
module sss_shifter
  import sss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  tx_word_t word_i,
  input  logic     fall_i,
  input  logic     active_i,
  output logic     empty_o,
  output logic     sdo_o
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              empty_d, sdo_d, step;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    empty_d = empty_o;
    step    = active_i & fall_i & ~empty_o;
    if (load_i) begin
      sh_d    = {word_i.bit9, word_i.data};
      cnt_d   = word_i.len9 ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
      empty_d = 1'b0;
    end else if (step) begin
      if (cnt_q == CNT_W'(1)) begin
        empty_d = 1'b1;
      end else begin
        sh_d  = {1'b0, sh_q[WORD_W-1:1]};
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    sdo_d = empty_d ? 1'b1 : sh_d[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      empty_o <= 1'b1;
      sdo_o   <= 1'b1;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      empty_o <= empty_d;
      sdo_o   <= sdo_d;
    end
  end

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(fall_i && active_i)) |=> $stable(sdo_o));
  // R9
  word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_i && cnt_q == CNT_W'(1)) |=> (empty_o && sdo_o));
endmodule

// File: rtl/sss_slave_tx.sv
module sss_slave_tx
  import sss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sck,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              host_bit9,
  input  logic              word9_sel,
  input  logic              port_on,
  input  logic              sync_sel,
  input  logic              clk_master_sel,
  input  logic              rx_cont_on,
  input  logic              rx_single_on,
  input  logic              tx_on,
  input  logic              irq_on,
  input  logic              ovf_clr,
  output logic              sdo,
  output logic              hold_empty,
  output logic              irq,
  output logic              shift_empty
  ,output logic             wr_ovf
);
  logic     active, fall, hold_full, take;
  tx_word_t in_word, held_word;

  assign active  = port_on & sync_sel & ~clk_master_sel & tx_on
                 & ~rx_cont_on & ~rx_single_on;
  assign in_word = '{len9: word9_sel, bit9: host_bit9, data: host_data};
  assign take    = active & hold_full & shift_empty;

  sss_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sck_async(ext_sck), .fall_o(fall));

  sss_hold_reg i_hold (
    .clk(clk), .rst_n(rst_n), .wr_i(host_wr), .word_i(in_word),
    .take_i(take), .ovf_clr_i(ovf_clr), .full_o(hold_full),
    .word_o(held_word), .ovf_o(wr_ovf));

  sss_shifter i_shift (
    .clk(clk), .rst_n(rst_n), .load_i(take), .word_i(held_word),
    .fall_i(fall), .active_i(active), .empty_o(shift_empty), .sdo_o(sdo));

  assign hold_empty = ~hold_full;
  assign irq        = hold_empty & irq_on;

  // R3
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold_full && shift_empty) |=> (!shift_empty && !hold_full));
  // R2
  idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && shift_empty) |=> (shift_empty && sdo));
endmodule

// File: tb/test_sss_slave_tx.sv
module test_sss_slave_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sck = 1'b0, host_wr = 1'b0, host_bit9 = 1'b0, word9_sel = 1'b0;
  logic [7:0] host_data = '0;
  logic port_on = 1'b1, sync_sel = 1'b1, clk_master_sel = 1'b0;
  logic rx_cont_on = 1'b0, rx_single_on = 1'b0, tx_on = 1'b1;
  logic irq_on = 1'b0, ovf_clr = 1'b0;
  logic sdo, hold_empty, irq, shift_empty, wr_ovf;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sss_slave_tx i_sss_slave_tx (
    .clk(clk), .rst_n(rst_n), .ext_sck(ext_sck), .host_wr(host_wr),
    .host_data(host_data), .host_bit9(host_bit9), .word9_sel(word9_sel),
    .port_on(port_on), .sync_sel(sync_sel), .clk_master_sel(clk_master_sel),
    .rx_cont_on(rx_cont_on), .rx_single_on(rx_single_on), .tx_on(tx_on),
    .irq_on(irq_on), .ovf_clr(ovf_clr), .sdo(sdo), .hold_empty(hold_empty),
    .irq(irq), .shift_empty(shift_empty), .wr_ovf(wr_ovf));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_word(logic [7:0] d, logic b9, logic m9);
    return m9 ? {b9, d} : {1'b0, d};
  endfunction

  task automatic host_write(logic [7:0] d, logic b9, logic m9);
    @(negedge clk);
    host_data = d; host_bit9 = b9; word9_sel = m9; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic clock_word(int n, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[i] = sdo;
      ext_sck = 1'b1;
      repeat (6) @(negedge clk);
      ext_sck = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic check_irq(string tag);
    check({tag, " R6 irq"}, irq, hold_empty & irq_on);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] got, w0, w1, w2;
    logic [7:0] d0, d1;
    logic b0, b1, m0, m1, two;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 shift_empty", shift_empty, 1);
    check("R1 hold_empty", hold_empty, 1);
    check("R1 wr_ovf", wr_ovf, 0);
    check("R1 sdo", sdo, 1);

    // R3 / R4 directed single word
    host_write(8'hA5, 1'b0, 1'b0);
    @(negedge clk);
    check("R3 shift_empty", shift_empty, 0);
    check("R3 hold_empty", hold_empty, 1);
    check("R3 sdo bit0", sdo, 1);
    repeat (2) @(negedge clk);
    clock_word(8, got);
    check("R4 lsb-first 8-bit word", got[7:0], 8'hA5);
    check("R9 shift_empty", shift_empty, 1);
    check("R9 sdo idle", sdo, 1);

    // R2 each enabling control held off in turn
    for (int k = 0; k < 6; k++) begin
      tx_on = (k != 0); port_on = (k != 1); sync_sel = (k != 2);
      clk_master_sel = (k == 3); rx_cont_on = (k == 4); rx_single_on = (k == 5);
      host_write(8'h3C, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      check("R2 inactive shift_empty", shift_empty, 1);
      check("R2 inactive hold_empty", hold_empty, 0);
      clock_word(3, got);
      check("R2 inactive sdo", got[2:0], 3'b111);
      tx_on = 1; port_on = 1; sync_sel = 1;
      clk_master_sel = 0; rx_cont_on = 0; rx_single_on = 0;
      repeat (3) @(negedge clk);
      check("R2 load after enable", shift_empty, 0);
      clock_word(9, got);
      check("R2 R7 word sent after enable", got, exp_word(8'h3C, 1'b1, 1'b1));
    end

    // R8 overflow
    irq_on = 1'b1;
    host_write(8'h11, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    host_write(8'h22, 1'b0, 1'b0);
    check_irq("R8 full");
    host_write(8'hFF, 1'b0, 1'b0);
    check("R8 ovf set", wr_ovf, 1);
    clock_word(8, got);
    check("R8 first word", got[7:0], 8'h11);
    clock_word(8, got);
    check("R8 second word kept", got[7:0], 8'h22);
    check("R8 dropped word not sent", shift_empty, 1);
    check("R8 ovf sticky", wr_ovf, 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R8 ovf cleared", wr_ovf, 0);

    // random mix with back-to-back pairs
    for (int it = 0; it < 40; it++) begin
      d0 = 8'($urandom); d1 = 8'($urandom);
      b0 = 1'($urandom); b1 = 1'($urandom);
      m0 = 1'($urandom); m1 = 1'($urandom);
      two = 1'($urandom); irq_on = 1'($urandom);
      w0 = exp_word(d0, b0, m0); w1 = exp_word(d1, b1, m1);
      host_write(d0, b0, m0);
      repeat (2) @(negedge clk);
      check("R3 random load", shift_empty, 0);
      if (two) begin
        host_write(d1, b1, m1);
        check("R5 second waits", hold_empty, 0);
      end else begin
        check("R3 holding empty", hold_empty, 1);
      end
      check_irq("random");
      clock_word(m0 ? 9 : 8, got);
      w2 = m0 ? got : {1'b0, got[7:0]};
      check("R4 R7 random word", w2, w0);
      if (two) begin
        check("R5 hold_empty after transfer", hold_empty, 1);
        check("R5 next word loaded", shift_empty, 0);
        check_irq("pair");
        clock_word(m1 ? 9 : 8, got);
        w2 = m1 ? got : {1'b0, got[7:0]};
        check("R5 R7 second word", w2, w1);
      end
      check("R9 idle after word", {shift_empty, sdo}, 2'b11);
      check("R8 no overflow", wr_ovf, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule